// File: doc/BRIEF.md
# UART Interrupt Enable, Prioritisation and Request Output

This block is the per-channel interrupt stage of a 16550-compatible UART that has extra flow-control features. Software writes an 8-bit enable mask over a small register bus. The block combines that mask with status levels and events from the rest of the channel: receive data ready, transmit holding register empty, the four line-status condition bits, a modem-status change level, a pulse that marks reception of the Xoff flow-control character, and the levels of the CTS input and RTS output. From these it drives one registered interrupt request and a 6-bit identification code that names the highest-priority pending cause.

Some causes are levels that follow their status input directly: line status, receive data and modem status. The others are events, latched into pending flags until software acknowledges them: a CTS or RTS rising edge, Xoff reception, and the transmit-empty transition. Software acknowledges a flag by reading the identification register, by reading the modem-status register, or by writing the transmit holding register. The upper four mask bits hold the CTS-edge, RTS-edge and Xoff enables and the sleep enable. An external enhanced-function gate input protects these four bits.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the mask reads 0x00, `intr` is 0, `irqId` is 0x01 (nothing pending) and `sleepEn` is 0.
- R2: A bus write to address 1 always loads mask bits 3:0. It loads mask bits 7:4 only while `enhGate` is 1; otherwise those bits keep their old value. `ierValue` shows the stored mask.
- R3: While `enhGate` is 0, mask bits 7:4 behave as zero. `sleepEn` (mask bit 4) is 0, and the Xoff and CTS/RTS-edge causes are never reported. They still read back as stored and take effect again when the gate returns to 1.
- R4: With mask bit 2 set, any nonzero `lineErr` bit reports code 0x06.
- R5: Mask bit 0 with `rxDataReady` high reports 0x04. Mask bit 3 with `modemDelta` high reports 0x00. Mask bit 1 with a latched transmit-empty event reports 0x02. That event is latched on a rising edge of `thrEmpty`.
- R6: When several causes are active, the code names the first of this list: line status 0x06, receive data 0x04, transmit empty 0x02, modem 0x00, Xoff 0x10, CTS/RTS edge 0x20.
- R7: A `xoffRcvd` pulse latches an Xoff event. With mask bit 5 enabled it reports 0x10. A read of address 2 clears the event only while `irqId` shows 0x10.
- R8: A rising edge of `ctsIn` or of `rtsOut` latches an edge event. It is reported as 0x20 when mask bit 7 (CTS) or mask bit 6 (RTS) is enabled. Only a read of address 6 clears it; a read of address 2 does not.
- R9: A latched transmit-empty event is cleared by a write to address 0. It is also cleared by a read of address 2 while `irqId` shows 0x02.
- R10: A cause whose mask bit is 0 never raises `intr` and never changes `irqId` from 0x01.
- R11: `intr` and `irqId` are registered. They change exactly one clock edge after a status input or the mask changes, and `intr` is 1 exactly when `irqId` is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| enhGate | input | 1 | Enhanced-function gate, protects and enables mask bits 7:4 |
| rxDataReady | input | 1 | Receive data available level |
| thrEmpty | input | 1 | Transmit holding register empty level |
| lineErr | input | 4 | Line status condition bits (overrun, parity, framing, break) |
| modemDelta | input | 1 | Modem status change level |
| xoffRcvd | input | 1 | One-cycle pulse on Xoff character reception |
| ctsIn | input | 1 | CTS input level |
| rtsOut | input | 1 | RTS output level |
| ierValue | output | 8 | Stored interrupt mask |
| sleepEn | output | 1 | Effective sleep enable |
| intr | output | 1 | Registered interrupt request |
| irqId | output | 6 | Registered identification code, 0x01 when idle |

## Verification
A corrupted mask bit appears at `ierValue` immediately. One edge later it also appears at `intr` and `irqId`, as a cause that is reported or suppressed against the expected priority. A stuck or lost pending flag shows up as a code that persists after the acknowledging access, or that never appears after its event. It becomes visible two edges after the event or the access. A gate that does not gate shows up as an upper-bit write that changes `ierValue`, or as a sleep or Xoff indication that stays on while the gate is clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 8;
  localparam int ID_W  = 6;

  localparam logic [ID_W-1:0] ID_NONE     = 6'h01;
  localparam logic [ID_W-1:0] ID_LINE     = 6'h06;
  localparam logic [ID_W-1:0] ID_RXDATA   = 6'h04;
  localparam logic [ID_W-1:0] ID_THRE     = 6'h02;
  localparam logic [ID_W-1:0] ID_MODEM    = 6'h00;
  localparam logic [ID_W-1:0] ID_XOFF     = 6'h10;
  localparam logic [ID_W-1:0] ID_FLOWEDGE = 6'h20;

  typedef struct packed {
    logic ierWr;
    logic iirRd;
    logic msrRd;
    logic thrWr;
  } busStrobe_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int ADDR_THR = 0,
  parameter int ADDR_IER = 1,
  parameter int ADDR_IIR = 2,
  parameter int ADDR_MSR = 6
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(ADDR_THR);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(ADDR_IER);
  localparam logic [ADDR_W-1:0] A_IIR = ADDR_W'(ADDR_IIR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(ADDR_MSR);

  always_comb begin
    strobe.ierWr = busWrEn && (busAddr == A_IER);
    strobe.thrWr = busWrEn && (busAddr == A_THR);
    strobe.iirRd = busRdEn && (busAddr == A_IIR);
    strobe.msrRd = busRdEn && (busAddr == A_MSR);
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int LS_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [IER_W-1:0] wrData,
  input  logic             enhGate,
  input  logic             rxDataReady,
  input  logic             thrEmpty,
  input  logic [LS_W-1:0]  lineErr,
  input  logic             modemDelta,
  input  logic             xoffRcvd,
  input  logic             ctsIn,
  input  logic             rtsOut,
  output logic [IER_W-1:0] ierValue,
  output logic             sleepEn,
  output logic             intr,
  output logic [ID_W-1:0]  irqId
);
  localparam int LOW_W    = IER_W / 2;
  localparam int N_FLOW   = 2;           // index 1 = CTS, index 0 = RTS
  localparam int FLOW_BIT = IER_W - N_FLOW;

  logic [IER_W-1:0]  ierQ, ierEff;
  logic [N_FLOW-1:0] flowLvl, flowPrev, flowRise, flowPend;
  logic              threPrev, threPend, threRise, xoffPend;
  logic              srcLine, srcRx, srcThre, srcModem, srcXoff, srcEdge;
  logic [ID_W-1:0]   nextId;
  logic              nextIntr;

  assign flowLvl = {ctsIn, rtsOut};
  assign ierEff  = {ierQ[IER_W-1:LOW_W] & {(IER_W-LOW_W){enhGate}}, ierQ[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ierQ <= '0;
    end else if (strobe.ierWr) begin
      ierQ[LOW_W-1:0] <= wrData[LOW_W-1:0];
      if (enhGate) ierQ[IER_W-1:LOW_W] <= wrData[IER_W-1:LOW_W];
    end
  end

  generate
    for (genvar g = 0; g < N_FLOW; g++) begin : gFlow
      assign flowRise[g] = flowLvl[g] & ~flowPrev[g];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          flowPrev[g] <= 1'b0;
          flowPend[g] <= 1'b0;
        end else begin
          flowPrev[g] <= flowLvl[g];
          flowPend[g] <= flowRise[g] | (flowPend[g] & ~strobe.msrRd);
        end
      end
    end
  endgenerate

  assign threRise = thrEmpty & ~threPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threPrev <= 1'b0;
      threPend <= 1'b0;
      xoffPend <= 1'b0;
    end else begin
      threPrev <= thrEmpty;
      threPend <= threRise |
                  (threPend & ~(strobe.thrWr | (strobe.iirRd && irqId == ID_THRE)));
      xoffPend <= xoffRcvd | (xoffPend & ~(strobe.iirRd && irqId == ID_XOFF));
    end
  end

  always_comb begin
    srcLine  = (|lineErr) & ierEff[2];
    srcRx    = rxDataReady & ierEff[0];
    srcThre  = threPend & ierEff[1];
    srcModem = modemDelta & ierEff[3];
    srcXoff  = xoffPend & ierEff[5];
    srcEdge  = |(flowPend & ierEff[IER_W-1:FLOW_BIT]);
    nextIntr = srcLine | srcRx | srcThre | srcModem | srcXoff | srcEdge;
    if      (srcLine)  nextId = ID_LINE;
    else if (srcRx)    nextId = ID_RXDATA;
    else if (srcThre)  nextId = ID_THRE;
    else if (srcModem) nextId = ID_MODEM;
    else if (srcXoff)  nextId = ID_XOFF;
    else if (srcEdge)  nextId = ID_FLOWEDGE;
    else               nextId = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intr  <= 1'b0;
      irqId <= ID_NONE;
    end else begin
      intr  <= nextIntr;
      irqId <= nextId;
    end
  end

  assign ierValue = ierQ;
  assign sleepEn  = ierEff[4];

  // R11: the request and the code always agree
  assert_intr_id_agree_R11: assert property (@(posedge clk) disable iff (!rstN)
    intr == (irqId != ID_NONE));

  // R2: upper mask bits are locked while the gate is clear
  assert_upper_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ierWr && !enhGate) |=> ierQ[IER_W-1:LOW_W] == $past(ierQ[IER_W-1:LOW_W]));

  // R3: gated causes cannot be reported while the gate is clear
  assert_gate_hides_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    !enhGate |=> (irqId != ID_XOFF) && (irqId != ID_FLOWEDGE));

  // R10: an all-zero mask keeps the request low
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ierQ == '0) |=> !intr);

  // R8: a modem-status read acknowledges edge events
  assert_edge_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.msrRd && flowRise == '0) |=> flowPend == '0);
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int LS_W     = 4,
  parameter int ADDR_THR = 0,
  parameter int ADDR_IER = 1,
  parameter int ADDR_IIR = 2,
  parameter int ADDR_MSR = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              enhGate,
  input  logic              rxDataReady,
  input  logic              thrEmpty,
  input  logic [LS_W-1:0]   lineErr,
  input  logic              modemDelta,
  input  logic              xoffRcvd,
  input  logic              ctsIn,
  input  logic              rtsOut,
  output logic [7:0]        ierValue,
  output logic              sleepEn,
  output logic              intr,
  output logic [5:0]        irqId
);
  busStrobe_t strobe;

  uart_irq_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_THR(ADDR_THR), .ADDR_IER(ADDR_IER),
    .ADDR_IIR(ADDR_IIR), .ADDR_MSR(ADDR_MSR)
  ) ctrl_i (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .strobe(strobe)
  );

  uart_irq_dp #(.LS_W(LS_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .enhGate(enhGate), .rxDataReady(rxDataReady), .thrEmpty(thrEmpty),
    .lineErr(lineErr), .modemDelta(modemDelta), .xoffRcvd(xoffRcvd),
    .ctsIn(ctsIn), .rtsOut(rtsOut), .ierValue(ierValue), .sleepEn(sleepEn),
    .intr(intr), .irqId(irqId)
  );
endmodule

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       enhGate = 1'b0, rxDataReady = 1'b0, thrEmpty = 1'b0;
  logic [3:0] lineErr = '0;
  logic       modemDelta = 1'b0, xoffRcvd = 1'b0, ctsIn = 1'b0, rtsOut = 1'b0;
  logic [7:0] ierValue;
  logic       sleepEn, intr;
  logic [5:0] irqId;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  uart_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .enhGate(enhGate),
    .rxDataReady(rxDataReady), .thrEmpty(thrEmpty), .lineErr(lineErr),
    .modemDelta(modemDelta), .xoffRcvd(xoffRcvd), .ctsIn(ctsIn),
    .rtsOut(rtsOut), .ierValue(ierValue), .sleepEn(sleepEn),
    .intr(intr), .irqId(irqId)
  );

  // {gate, ier[7:0], rx, ls[3:0], md, expIntr, expId[5:0]}
  typedef struct packed {
    logic       gate;
    logic [7:0] ier;
    logic       rx;
    logic [3:0] ls;
    logic       md;
    logic       expIntr;
    logic [5:0] expId;
  } vec_t;

  localparam int NV = 10;
  localparam logic [21:0] VECS [NV] = '{
    {1'b0, 8'h00, 1'b1, 4'hF, 1'b1, 1'b0, 6'h01},  // R10 all masked
    {1'b0, 8'h01, 1'b1, 4'h0, 1'b0, 1'b1, 6'h04},  // R5 rx data
    {1'b0, 8'h04, 1'b0, 4'h1, 1'b0, 1'b1, 6'h06},  // R4 overrun
    {1'b0, 8'h04, 1'b0, 4'h8, 1'b0, 1'b1, 6'h06},  // R4 break
    {1'b0, 8'h08, 1'b0, 4'h0, 1'b1, 1'b1, 6'h00},  // R5 modem
    {1'b0, 8'h0F, 1'b1, 4'h2, 1'b1, 1'b1, 6'h06},  // R6 line beats all
    {1'b0, 8'h0B, 1'b1, 4'h2, 1'b1, 1'b1, 6'h04},  // R6 line masked
    {1'b0, 8'h0A, 1'b1, 4'h0, 1'b1, 1'b1, 6'h00},  // R10 rx masked
    {1'b0, 8'h0D, 1'b0, 4'h0, 1'b0, 1'b0, 6'h01},  // R10 idle
    {1'b0, 8'h0B, 1'b0, 4'h4, 1'b0, 1'b0, 6'h01}   // R10 line masked
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 intr", intr, 0);
    check("R1 irqId", irqId, 6'h01);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ierValue", ierValue, 8'h00);
    check("R1 sleepEn", sleepEn, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      enhGate = v.gate;
      wrReg(3'd1, v.ier);
      rxDataReady = v.rx; lineErr = v.ls; modemDelta = v.md;
      settle();
      check($sformatf("R6 vec%0d intr", i), intr, v.expIntr);
      check($sformatf("R6 vec%0d irqId", i), irqId, v.expId);
    end
    rxDataReady = 0; lineErr = 0; modemDelta = 0;
    wrReg(3'd1, 8'h00);

    // R2: upper bits locked while gate clear
    enhGate = 0;
    wrReg(3'd1, 8'hF5);
    check("R2 gated write", ierValue, 8'h05);
    enhGate = 1;
    wrReg(3'd1, 8'hF5);
    check("R2 open write", ierValue, 8'hF5);
    check("R3 sleep on", sleepEn, 1);
    enhGate = 0;
    #1;
    check("R3 sleep gated", sleepEn, 0);
    check("R3 readback kept", ierValue, 8'hF5);
    wrReg(3'd1, 8'h00);
    check("R2 gated clear keeps upper", ierValue, 8'hF0);

    // R7 / R3: Xoff event
    enhGate = 1;
    wrReg(3'd1, 8'h20);
    @(negedge clk); xoffRcvd = 1; @(negedge clk); xoffRcvd = 0;
    settle();
    check("R7 xoff reported", irqId, 6'h10);
    check("R7 xoff intr", intr, 1);
    enhGate = 0; settle();
    check("R3 xoff hidden", irqId, 6'h01);
    enhGate = 1; settle();
    check("R3 xoff back", irqId, 6'h10);
    rdReg(3'd6); settle();
    check("R7 msr read no clear", irqId, 6'h10);
    rdReg(3'd2); settle();
    check("R7 iir clears xoff", irqId, 6'h01);

    // R8: CTS / RTS edges
    wrReg(3'd1, 8'hC0);
    @(negedge clk); ctsIn = 1; settle();
    check("R8 cts edge", irqId, 6'h20);
    rdReg(3'd2); settle();
    check("R8 iir no clear", irqId, 6'h20);
    rdReg(3'd6); settle();
    check("R8 msr clears", irqId, 6'h01);
    @(negedge clk); rtsOut = 1; settle();
    check("R8 rts edge", intr, 1);
    rdReg(3'd6); settle();
    check("R8 rts cleared", intr, 0);
    ctsIn = 0; rtsOut = 0;
    wrReg(3'd1, 8'h40);
    @(negedge clk); ctsIn = 1; settle();
    check("R8 cts masked by bit7", irqId, 6'h01);
    rdReg(3'd6); ctsIn = 0;

    // R9 / R5: transmit empty
    wrReg(3'd1, 8'h02);
    @(negedge clk); thrEmpty = 1; settle();
    check("R5 thre", irqId, 6'h02);
    wrReg(3'd0, 8'h55); settle();
    check("R9 thr write clears", irqId, 6'h01);
    thrEmpty = 0; @(negedge clk); thrEmpty = 1; settle();
    check("R9 thre again", irqId, 6'h02);
    rdReg(3'd2); settle();
    check("R9 iir clears", irqId, 6'h01);

    // R6: receive data beats Xoff
    wrReg(3'd1, 8'h21);
    @(negedge clk); xoffRcvd = 1; rxDataReady = 1;
    @(negedge clk); xoffRcvd = 0; settle();
    check("R6 rx over xoff", irqId, 6'h04);
    rdReg(3'd2); rxDataReady = 0; settle();
    check("R6 xoff kept when not shown", irqId, 6'h10);
    rdReg(3'd2); settle();

    // R11: one-edge latency
    wrReg(3'd1, 8'h01);
    @(negedge clk);
    rxDataReady = 1; #1;
    check("R11 before edge", intr, 0);
    @(negedge clk);
    check("R11 after one edge", intr, 1);
    check("R11 id after one edge", irqId, 6'h04);
    rxDataReady = 0;
    @(negedge clk);
    check("R11 drop after one edge", intr, 0);

    finishRun();
  end
endmodule